// File: doc/BRIEF.md
# Windowed Bus Master Address Mapper

This block turns the local address of a 16-bit processor into the address and address-modifier code it drives as master on a wide shared system bus. One local address bit picks one of two map registers. The low 16 local bits pass straight through, and the chosen map register supplies the upper part of the system address. The processor therefore sees two 64 KB windows, and each can be placed on any 64 KB boundary of the system space, so 128 KB is reachable at any one time.

A mode input chooses between 32-bit and 24-bit master addressing. In 32-bit mode all 16 map bits form the upper address, and the 6-bit modifier comes from a separate register that the host loads through its own write port. In 24-bit mode the map register's low byte forms address bits 23..16. Six bits of its high byte supply the modifier, and that same modifier value is also placed, zero-extended, on address bits 31..24. The processor loads the map registers through a local write strobe. The address and modifier outputs are captured when a master cycle starts and stay fixed until the cycle ends.

Top module: `bus_window_mapper`

## Requirements
- R1: While rst_ni is low and after reset, sys_addr_o and sys_am_o are zero, and both map registers and the modifier register hold zero.
- R2: loc_addr_i[16] selects the map register that supplies the upper address: 0 selects map register 0 and 1 selects map register 1.
- R3: sys_addr_o[15:0] equals loc_addr_i[15:0] as sampled at cycle start, in both modes.
- R4: With mode32_i=1, sys_addr_o[31:16] is the full selected map register and sys_am_o is the modifier register. The map register's high byte has no effect on sys_am_o, so 24-bit targets are reached by loading a 24-bit modifier code.
- R5: With mode32_i=0, sys_addr_o[23:16] is the selected map register bits 7..0, sys_am_o is its bits 13..8, and sys_addr_o[31:24] is {2'b00, sys_am_o}.
- R6: A host write (am_wr_i=1) stores am_wdata_i[5:0] in the modifier register. Bits 7..6 are discarded.
- R7: A local write (map_wr_i=1) loads map_wdata_i into the map register named by map_sel_i (0 or 1). The other register keeps its value.
- R8: An edge at which cyc_start_i=1 and no cycle is open captures a new address and modifier, which are visible after that edge. Without such an edge, the outputs do not change.
- R9: While a cycle is open, changes to loc_addr_i, mode32_i, the map registers or the modifier register, and any further cyc_start_i pulse, leave the outputs unchanged.
- R10: cyc_end_i closes the open cycle. The next cyc_start_i then captures fresh values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_wr_i | input | 1 | Local strobe that loads a map register |
| map_sel_i | input | 1 | Selects which map register is loaded |
| map_wdata_i | input | 16 | Map register write data |
| am_wr_i | input | 1 | Host strobe that loads the modifier register |
| am_wdata_i | input | 8 | Host write byte; only the low 6 bits are kept |
| mode32_i | input | 1 | 1: 32-bit master mode, 0: 24-bit master mode |
| cyc_start_i | input | 1 | Start of a master cycle |
| cyc_end_i | input | 1 | End of the open master cycle |
| loc_addr_i | input | 17 | Local processor address; bit 16 selects the window |
| sys_addr_o | output | 32 | System bus address |
| sys_am_o | output | 6 | System bus address modifier |

## Verification
The assertions assume that the control inputs are single-cycle pulses synchronous to clk_i and that cyc_end_i is raised only while a cycle is open. The checker follows whether a cycle is open using those ports alone. The stimulus changes inputs only on the falling edge and pulses cyc_start_i only once the previous cycle has been closed by cyc_end_i, except in the scenario that deliberately restarts inside an open cycle. Map and modifier writes never fall on a capture edge, so each expected value depends only on register contents that are already settled.

// File: rtl/bus_window_mapper_pkg.sv
package bus_window_mapper_pkg;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned MAP_W  = 16;
  localparam int unsigned AM_W   = 6;
  localparam int unsigned HOST_W = 8;
  localparam int unsigned N_MAP  = 2;

  typedef enum logic {CYC_IDLE = 1'b0, CYC_OPEN = 1'b1} cyc_state_e;
  typedef enum logic {MODE_A24 = 1'b0, MODE_A32 = 1'b1} addr_mode_e;
endpackage

// File: rtl/map_regfile.sv
module map_regfile #(
  parameter int unsigned N_MAP = 2,
  parameter int unsigned MAP_W = 16,
  localparam int unsigned SEL_W = (N_MAP > 1) ? $clog2(N_MAP) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [MAP_W-1:0]             wdata_i,
  output logic [N_MAP-1:0][MAP_W-1:0]  map_o
);
  for (genvar g = 0; g < N_MAP; g++) begin : g_map
    logic hit;
    assign hit = wr_i && (sel_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  map_o[g] <= '0;
      else if (hit) map_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/am_reg.sv
module am_reg #(
  parameter int unsigned HOST_W = 8,
  parameter int unsigned AM_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [AM_W-1:0]   am_o
);
  // upper host bits are discarded on purpose
  logic unused_hi;
  assign unused_hi = ^wdata_i[HOST_W-1:AM_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   am_o <= '0;
    else if (wr_i) am_o <= wdata_i[AM_W-1:0];
  end
endmodule

// File: rtl/addr_compose.sv
module addr_compose
  import bus_window_mapper_pkg::*;
#(
  parameter int unsigned N_MAP = 2,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned MAP_W = 16,
  parameter int unsigned AM_W  = 6,
  localparam int unsigned SEL_W  = (N_MAP > 1) ? $clog2(N_MAP) : 1,
  localparam int unsigned LOC_W  = OFS_W + SEL_W,
  localparam int unsigned SYS_W  = OFS_W + MAP_W,
  localparam int unsigned HALF_W = MAP_W / 2
) (
  input  logic [LOC_W-1:0]             loc_addr_i,
  input  logic [N_MAP-1:0][MAP_W-1:0]  map_i,
  input  logic [AM_W-1:0]              am_reg_i,
  input  addr_mode_e                   mode_i,
  output logic [SYS_W-1:0]             addr_o,
  output logic [AM_W-1:0]              am_o
);
  logic [MAP_W-1:0]  win;
  logic [AM_W-1:0]   am24;
  logic [HALF_W-1:0] top24;

  assign win   = map_i[loc_addr_i[OFS_W +: SEL_W]];
  assign am24  = win[HALF_W +: AM_W];
  assign top24 = HALF_W'(am24);

  always_comb begin
    if (mode_i == MODE_A32) begin
      addr_o = {win, loc_addr_i[OFS_W-1:0]};
      am_o   = am_reg_i;
    end else begin
      addr_o = {top24, win[HALF_W-1:0], loc_addr_i[OFS_W-1:0]};
      am_o   = am24;
    end
  end
endmodule

// File: rtl/cycle_hold.sv
module cycle_hold
  import bus_window_mapper_pkg::*;
#(
  parameter int unsigned SYS_W = 32,
  parameter int unsigned AM_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [SYS_W-1:0] addr_i,
  input  logic [AM_W-1:0]  am_i,
  output logic [SYS_W-1:0] addr_o,
  output logic [AM_W-1:0]  am_o
);
  cyc_state_e state_q;
  logic       capture;

  assign capture = (state_q == CYC_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CYC_IDLE;
    end else if (capture) begin
      state_q <= CYC_OPEN;
    end else if (state_q == CYC_OPEN && end_i) begin
      state_q <= CYC_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      am_o   <= '0;
    end else if (capture) begin
      addr_o <= addr_i;
      am_o   <= am_i;
    end
  end
endmodule

// File: rtl/bus_window_mapper.sv
module bus_window_mapper
  import bus_window_mapper_pkg::*;
#(
  parameter int unsigned N_MAP  = bus_window_mapper_pkg::N_MAP,
  parameter int unsigned OFS_W  = bus_window_mapper_pkg::OFS_W,
  parameter int unsigned MAP_W  = bus_window_mapper_pkg::MAP_W,
  parameter int unsigned AM_W   = bus_window_mapper_pkg::AM_W,
  parameter int unsigned HOST_W = bus_window_mapper_pkg::HOST_W,
  localparam int unsigned SEL_W = (N_MAP > 1) ? $clog2(N_MAP) : 1,
  localparam int unsigned LOC_W = OFS_W + SEL_W,
  localparam int unsigned SYS_W = OFS_W + MAP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_wr_i,
  input  logic [SEL_W-1:0]  map_sel_i,
  input  logic [MAP_W-1:0]  map_wdata_i,
  input  logic              am_wr_i,
  input  logic [HOST_W-1:0] am_wdata_i,
  input  logic              mode32_i,
  input  logic              cyc_start_i,
  input  logic              cyc_end_i,
  input  logic [LOC_W-1:0]  loc_addr_i,
  output logic [SYS_W-1:0]  sys_addr_o,
  output logic [AM_W-1:0]   sys_am_o
);
  logic [N_MAP-1:0][MAP_W-1:0] map_q;
  logic [AM_W-1:0]             am_q;
  logic [SYS_W-1:0]            addr_d;
  logic [AM_W-1:0]             am_d;
  addr_mode_e                  mode;

  assign mode = addr_mode_e'(mode32_i);

  map_regfile #(.N_MAP(N_MAP), .MAP_W(MAP_W)) u_maps (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(map_wr_i),
    .sel_i(map_sel_i), .wdata_i(map_wdata_i), .map_o(map_q)
  );

  am_reg #(.HOST_W(HOST_W), .AM_W(AM_W)) u_am (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(am_wr_i),
    .wdata_i(am_wdata_i), .am_o(am_q)
  );

  addr_compose #(.N_MAP(N_MAP), .OFS_W(OFS_W), .MAP_W(MAP_W), .AM_W(AM_W)) u_compose (
    .loc_addr_i(loc_addr_i), .map_i(map_q), .am_reg_i(am_q),
    .mode_i(mode), .addr_o(addr_d), .am_o(am_d)
  );

  cycle_hold #(.SYS_W(SYS_W), .AM_W(AM_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cyc_start_i), .end_i(cyc_end_i),
    .addr_i(addr_d), .am_i(am_d), .addr_o(sys_addr_o), .am_o(sys_am_o)
  );
endmodule

// File: rtl/bus_window_mapper_chk.sv
module bus_window_mapper_chk #(
  parameter int unsigned N_MAP = 2,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned MAP_W = 16,
  parameter int unsigned AM_W  = 6,
  localparam int unsigned SEL_W  = (N_MAP > 1) ? $clog2(N_MAP) : 1,
  localparam int unsigned LOC_W  = OFS_W + SEL_W,
  localparam int unsigned SYS_W  = OFS_W + MAP_W,
  localparam int unsigned HALF_W = MAP_W / 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        mode32_i,
  input logic                        cyc_start_i,
  input logic                        cyc_end_i,
  input logic [LOC_W-1:0]            loc_addr_i,
  input logic [SYS_W-1:0]            sys_addr_o,
  input logic [AM_W-1:0]             sys_am_o,
  input logic [N_MAP-1:0][MAP_W-1:0] map_q,
  input logic [AM_W-1:0]             am_q
);
  logic open_q;
  logic cap;
  assign cap = !open_q && cyc_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                open_q <= 1'b0;
    else if (cap)               open_q <= 1'b1;
    else if (open_q && cyc_end_i) open_q <= 1'b0;
  end

  always @(posedge clk_i) begin
    if (rst_ni === 1'b0) begin
      p_reset_zero_r1: assert (sys_addr_o == '0 && sys_am_o == '0);
    end
  end

  p_win_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && mode32_i) |=> sys_addr_o[SYS_W-1:OFS_W] == $past(map_q[loc_addr_i[OFS_W +: SEL_W]]));

  p_low_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> sys_addr_o[OFS_W-1:0] == $past(loc_addr_i[OFS_W-1:0]));

  p_am32_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && mode32_i) |=> sys_am_o == $past(am_q));

  p_am24_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && !mode32_i) |=> sys_addr_o[SYS_W-1:SYS_W-HALF_W] == HALF_W'(sys_am_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> ($stable(sys_addr_o) && $stable(sys_am_o)));
endmodule

bind bus_window_mapper bus_window_mapper_chk #(
  .N_MAP(N_MAP), .OFS_W(OFS_W), .MAP_W(MAP_W), .AM_W(AM_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode32_i(mode32_i),
  .cyc_start_i(cyc_start_i), .cyc_end_i(cyc_end_i), .loc_addr_i(loc_addr_i),
  .sys_addr_o(sys_addr_o), .sys_am_o(sys_am_o), .map_q(map_q), .am_q(am_q)
);

// File: tb/bus_window_mapper_tb.sv
module bus_window_mapper_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        map_wr_i = 1'b0;
  logic        map_sel_i = 1'b0;
  logic [15:0] map_wdata_i = '0;
  logic        am_wr_i = 1'b0;
  logic [7:0]  am_wdata_i = '0;
  logic        mode32_i = 1'b1;
  logic        cyc_start_i = 1'b0;
  logic        cyc_end_i = 1'b0;
  logic [16:0] loc_addr_i = '0;
  logic [31:0] sys_addr_o;
  logic [5:0]  sys_am_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  bus_window_mapper u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .map_wr_i(map_wr_i), .map_sel_i(map_sel_i),
    .map_wdata_i(map_wdata_i), .am_wr_i(am_wr_i), .am_wdata_i(am_wdata_i),
    .mode32_i(mode32_i), .cyc_start_i(cyc_start_i), .cyc_end_i(cyc_end_i),
    .loc_addr_i(loc_addr_i), .sys_addr_o(sys_addr_o), .sys_am_o(sys_am_o)
  );

  task automatic chk(string req, logic [31:0] ea, logic [5:0] em);
    checks++;
    if (sys_addr_o !== ea || sys_am_o !== em) begin
      fails++;
      $display("FAIL %s addr=%h am=%h expected addr=%h am=%h", req, sys_addr_o, sys_am_o, ea, em);
    end
  endtask

  task automatic wr_map(logic sel, logic [15:0] v);
    @(negedge clk_i); map_wr_i = 1'b1; map_sel_i = sel; map_wdata_i = v;
    @(negedge clk_i); map_wr_i = 1'b0;
  endtask

  task automatic wr_am(logic [7:0] v);
    @(negedge clk_i); am_wr_i = 1'b1; am_wdata_i = v;
    @(negedge clk_i); am_wr_i = 1'b0;
  endtask

  task automatic start_cyc(logic [16:0] a, logic m32);
    @(negedge clk_i); loc_addr_i = a; mode32_i = m32; cyc_start_i = 1'b1;
    @(negedge clk_i); cyc_start_i = 1'b0;
  endtask

  task automatic end_cyc();
    @(negedge clk_i); cyc_end_i = 1'b1;
    @(negedge clk_i); cyc_end_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i); chk("R1 in reset", 32'h0, 6'h0);
    rst_ni = 1'b1;
    @(negedge clk_i); chk("R1 after reset", 32'h0, 6'h0);
    start_cyc(17'h1_ABCD, 1'b1); chk("R1 cleared regs", 32'h0000_ABCD, 6'h00);
    end_cyc();
  endtask

  task automatic t_mode32();
    wr_map(1'b0, 16'h1234); wr_map(1'b1, 16'hBEEF); wr_am(8'h3D);
    start_cyc(17'h0_5678, 1'b1); chk("R2 R3 R4 window0", 32'h1234_5678, 6'h3D); end_cyc();
    start_cyc(17'h1_0010, 1'b1); chk("R2 R4 window1", 32'hBEEF_0010, 6'h3D); end_cyc();
  endtask

  task automatic t_am_mask();
    wr_am(8'hFF);
    start_cyc(17'h0_0001, 1'b1); chk("R6 mask FF", 32'h1234_0001, 6'h3F); end_cyc();
    wr_am(8'hC5);
    start_cyc(17'h0_0002, 1'b1); chk("R6 mask C5", 32'h1234_0002, 6'h05); end_cyc();
  endtask

  task automatic t_mode24();
    wr_map(1'b1, 16'h7A55); wr_map(1'b0, 16'hC901);
    start_cyc(17'h1_F00D, 1'b0); chk("R5 window1", 32'h3A55_F00D, 6'h3A); end_cyc();
    start_cyc(17'h0_0F0F, 1'b0); chk("R5 window0 high bits dropped", 32'h0901_0F0F, 6'h09); end_cyc();
  endtask

  task automatic t_a24_code_in32();
    wr_am(8'h39);
    start_cyc(17'h1_4444, 1'b1); chk("R4 map high byte not modifier", 32'h7A55_4444, 6'h39); end_cyc();
  endtask

  task automatic t_map_sel();
    wr_map(1'b0, 16'h0F0F);
    start_cyc(17'h1_0000, 1'b1); chk("R7 other map kept", 32'h7A55_0000, 6'h39); end_cyc();
    start_cyc(17'h0_0000, 1'b1); chk("R7 selected map loaded", 32'h0F0F_0000, 6'h39); end_cyc();
  endtask

  task automatic t_timing();
    @(negedge clk_i); loc_addr_i = 17'h1_1111; mode32_i = 1'b0;
    @(negedge clk_i); chk("R8 no start no change", 32'h0F0F_0000, 6'h39);
    cyc_start_i = 1'b1;
    chk("R8 before capture edge", 32'h0F0F_0000, 6'h39);
    @(negedge clk_i); cyc_start_i = 1'b0;
    chk("R8 after capture edge", 32'h3A55_1111, 6'h3A);
  endtask

  task automatic t_hold();
    @(negedge clk_i); loc_addr_i = 17'h0_2222; mode32_i = 1'b1;
    @(negedge clk_i); chk("R9 inputs changed", 32'h3A55_1111, 6'h3A);
    wr_map(1'b1, 16'h5555); wr_am(8'h11);
    start_cyc(17'h0_3333, 1'b1); chk("R9 restart ignored", 32'h3A55_1111, 6'h3A);
    end_cyc();
    chk("R10 end keeps outputs", 32'h3A55_1111, 6'h3A);
    start_cyc(17'h1_4321, 1'b1); chk("R10 fresh capture", 32'h5555_4321, 6'h11);
    end_cyc();
  endtask

  initial begin
    t_reset();
    t_mode32();
    t_am_mask();
    t_mode24();
    t_a24_code_in32();
    t_map_sel();
    t_timing();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule